// File: doc/BRIEF.md
# Pulse-width bus frame transmitter

This block sends one frame at a time onto a single-wire bus on which each bit is coded by the width of a low pulse. The caller places up to sixteen 4-bit payload nibbles on a flat input vector, gives their count and pulses a start strobe. The block copies the payload and adds a checksum nibble. It then shifts the whole frame out, one bit slot after another. The output pin drives an inverting open-collector stage, so a high level on the pin pulls the bus low. The bus pull-up at the far end restores the idle level when the pin is low.

Every bit takes a slot of fixed length. The bus is pulled low at the start of the slot. It is released after a short time for a zero and a long time for a one, and stays released for the rest of the slot. All times come from the system clock: the defaults give 0.6 ms, 1.8 ms and a 3.0 ms slot at 16 MHz. The block holds `busy` for the whole frame and pulses `done` once when the frame is over. Typical frames are an address nibble followed by one or more command nibbles. For example, an address 0x1 with command 0x8 goes out with checksum 0xA, and a reply of 0x9, 0x8 goes out with checksum 0x2.

Top module: `pwb_tx`

## Requirements
- R1: During reset and while idle after reset, `bus_pull`, `busy` and `done` are 0.
- R2: A `start` seen at a clock edge while `busy` is 0 and `nib_count` is in 1..MAX_NIBS is accepted. In the following cycle `busy` is 1 and `bus_pull` is 1.
- R3: A 0 bit holds `bus_pull` at 1 for the first ZERO_CYC cycles of its PERIOD_CYC-cycle slot and at 0 for the remaining cycles.
- R4: A 1 bit holds `bus_pull` at 1 for the first ONE_CYC cycles of its PERIOD_CYC-cycle slot and at 0 for the remaining cycles.
- R5: The slots follow one another with no gap. Payload nibble 0 (`nibbles[3:0]`) goes first, then nibble k (`nibbles[4k+3:4k]`) in rising k up to `nib_count`-1, then the checksum. Each nibble is sent most significant bit first.
- R6: The checksum nibble equals the XOR of the `nib_count` payload nibbles plus one, modulo 16. Nibbles 1 then 8 give 0xA, and a single nibble 0xF gives 0x0.
- R7: `busy` stays 1 for exactly (`nib_count`+1)·4·PERIOD_CYC consecutive cycles per frame.
- R8: `done` is 1 for exactly one cycle, the first cycle in which `busy` is 0 again. A `start` given in that cycle is accepted.
- R9: While `busy` is 1, `start`, `nib_count` and `nibbles` have no effect on the frame being sent.
- R10: `bus_pull` is 0 in every cycle in which `busy` is 0.
- R11: A `start` with `nib_count` equal to 0 or above MAX_NIBS is ignored, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times every pulse |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send a frame, sampled at the clock edge |
| nib_count | input | $clog2(MAX_NIBS+1) | Number of payload nibbles, valid range 1..MAX_NIBS |
| nibbles | input | MAX_NIBS·NIB_W | Payload; nibble k sits at bits [4k+3:4k] |
| bus_pull | output | 1 | Drive to the inverting stage; 1 pulls the bus low |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse after the last checksum slot |

## Verification
Two situations are hard to reach from the ports, because they need a strobe placed on one exact cycle. The first is a `start` that arrives in the single cycle in which `done` is high. The second is a `start` carrying a different count and payload that arrives in the middle of a frame. The stimulus waits for its own model to predict the `done` cycle and raises `start` in that same cycle. For the second case it injects the competing request a few cycles into a frame and leaves the altered payload on the inputs until the first frame ends. A pulse decoder in the bench turns the `bus_pull` widths back into bits, so the order of the slots and the checksum are checked from the wire itself.

// File: rtl/pwb_pkg.sv
// Shared types and helpers for the pulse-width bus transmitter.
package pwb_pkg;

   // Frame sequencer state.
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } pwb_state_e;

   // Converts a duration in microseconds to clock cycles.
   function automatic int us_to_cycles(input longint hz, input longint us);
      return int'((hz * us) / 64'd1_000_000);
   endfunction

endpackage

// File: rtl/pwb_cksum.sv
// Combinational checksum: XOR of the first `count` nibbles, plus one.
module pwb_cksum #(
   parameter int NIB_W    = 4,
   parameter int MAX_NIBS = 16,
   parameter int CNT_W    = $clog2(MAX_NIBS + 1)
) (
   input  logic [MAX_NIBS*NIB_W-1:0] payload,
   input  logic [CNT_W-1:0]          count,
   output logic [NIB_W-1:0]          cksum
);

   logic [MAX_NIBS-1:0][NIB_W-1:0] masked;
   logic [NIB_W-1:0]               acc;

   // Nibbles at or above the count take no part in the sum.
   for (genvar i = 0; i < MAX_NIBS; i++) begin : g_mask
      localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
      assign masked[i] = (IDX < count) ? payload[i*NIB_W +: NIB_W] : '0;
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < MAX_NIBS; k++) begin
         acc = acc ^ masked[k];
      end
      cksum = acc + NIB_W'(1);
   end

endmodule

// File: rtl/pwb_bit_timer.sv
// Slot timer: one phase counter per bit slot and the pulse-width compare.
module pwb_bit_timer #(
   parameter int PERIOD_CYC = 48000,
   parameter int ZERO_CYC   = 9600,
   parameter int ONE_CYC    = 28800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic bit_val,
   output logic pull,
   output logic period_end
);

   localparam int PH_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
   localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PERIOD_CYC - 1);
   localparam logic [PH_W-1:0] W_ZERO   = PH_W'(ZERO_CYC);
   localparam logic [PH_W-1:0] W_ONE    = PH_W'(ONE_CYC);

   logic [PH_W-1:0] ph;
   logic [PH_W-1:0] width;

   assign period_end = run && (ph == PH_LAST);
   assign width      = bit_val ? W_ONE : W_ZERO;
   assign pull       = run && (ph < width);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (!run || period_end) begin
         ph <= '0;
      end else begin
         ph <= ph + PH_W'(1);
      end
   end

endmodule

// File: rtl/pwb_frame_seq.sv
// Frame sequencer: holds the frame image and walks it nibble by nibble,
// most significant bit first.
module pwb_frame_seq
   import pwb_pkg::*;
#(
   parameter int NIB_W    = 4,
   parameter int MAX_NIBS = 16,
   parameter int CNT_W    = $clog2(MAX_NIBS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [CNT_W-1:0]          count,
   input  logic [MAX_NIBS*NIB_W-1:0] payload,
   input  logic [NIB_W-1:0]          cksum,
   input  logic                      step,
   output logic                      busy,
   output logic                      done,
   output logic                      cur_bit
);

   localparam int NSLOT = MAX_NIBS + 1;
   localparam int BIT_W = $clog2(NIB_W);
   localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(NIB_W - 1);

   pwb_state_e                  state;
   logic [NSLOT-1:0][NIB_W-1:0] slot_q;
   logic [NSLOT-1:0][NIB_W-1:0] slot_d;
   logic [CNT_W-1:0]            nib_idx;
   logic [CNT_W-1:0]            last_idx;
   logic [BIT_W-1:0]            bit_idx;
   logic                        done_q;

   // The checksum lands in the slot right after the last payload nibble.
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
      if (i < MAX_NIBS) begin : g_pay
         assign slot_d[i] = (IDX == count) ? cksum : payload[i*NIB_W +: NIB_W];
      end else begin : g_tail
         assign slot_d[i] = (IDX == count) ? cksum : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (load) begin
         slot_q <= slot_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         nib_idx  <= '0;
         last_idx <= '0;
         bit_idx  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (load) begin
                  state    <= ST_SEND;
                  nib_idx  <= '0;
                  last_idx <= count;
                  bit_idx  <= BIT_TOP;
               end
            end
            ST_SEND: begin
               if (step) begin
                  if (bit_idx == '0) begin
                     if (nib_idx == last_idx) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        nib_idx <= nib_idx + CNT_W'(1);
                        bit_idx <= BIT_TOP;
                     end
                  end else begin
                     bit_idx <= bit_idx - BIT_W'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state == ST_SEND);
   assign done    = done_q;
   assign cur_bit = slot_q[nib_idx][bit_idx];

endmodule

// File: rtl/pwb_tx.sv
// Pulse-width bus frame transmitter, top level.
module pwb_tx #(
   parameter int NIB_W     = 4,
   parameter int MAX_NIBS  = 16,
   parameter int CLK_HZ    = 16_000_000,
   parameter int ZERO_US   = 600,
   parameter int ONE_US    = 1800,
   parameter int PERIOD_US = 3000,
   localparam int CNT_W    = $clog2(MAX_NIBS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [CNT_W-1:0]          nib_count,
   input  logic [MAX_NIBS*NIB_W-1:0] nibbles,
   output logic                      bus_pull,
   output logic                      busy,
   output logic                      done
);

   localparam int ZERO_CYC   = pwb_pkg::us_to_cycles(CLK_HZ, ZERO_US);
   localparam int ONE_CYC    = pwb_pkg::us_to_cycles(CLK_HZ, ONE_US);
   localparam int PERIOD_CYC = pwb_pkg::us_to_cycles(CLK_HZ, PERIOD_US);

   // Elaboration-time parameter checks.
   if (NIB_W < 2) begin : g_bad_nib
      $error("pwb_tx: NIB_W must be at least 2");
   end
   if (MAX_NIBS < 1) begin : g_bad_max
      $error("pwb_tx: MAX_NIBS must be at least 1");
   end
   if (ZERO_CYC < 1) begin : g_bad_zero
      $error("pwb_tx: short pulse rounds to zero cycles");
   end
   if (ONE_CYC <= ZERO_CYC) begin : g_bad_one
      $error("pwb_tx: long pulse must exceed short pulse");
   end
   if (PERIOD_CYC <= ONE_CYC) begin : g_bad_period
      $error("pwb_tx: slot must exceed long pulse");
   end

   logic             count_ok;
   logic             accept;
   logic [NIB_W-1:0] cksum;
   logic             cur_bit;
   logic             period_end;

   assign count_ok = (nib_count != '0) && (nib_count <= CNT_W'(MAX_NIBS));
   assign accept   = start && !busy && count_ok;

   pwb_cksum #(
      .NIB_W    (NIB_W),
      .MAX_NIBS (MAX_NIBS),
      .CNT_W    (CNT_W)
   ) u_cksum (
      .payload (nibbles),
      .count   (nib_count),
      .cksum   (cksum)
   );

   pwb_frame_seq #(
      .NIB_W    (NIB_W),
      .MAX_NIBS (MAX_NIBS),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .count   (nib_count),
      .payload (nibbles),
      .cksum   (cksum),
      .step    (period_end),
      .busy    (busy),
      .done    (done),
      .cur_bit (cur_bit)
   );

   pwb_bit_timer #(
      .PERIOD_CYC (PERIOD_CYC),
      .ZERO_CYC   (ZERO_CYC),
      .ONE_CYC    (ONE_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy),
      .bit_val    (cur_bit),
      .pull       (bus_pull),
      .period_end (period_end)
   );

endmodule

// File: rtl/pwb_tx_chk.sv
// Property checker for pwb_tx, attached with bind.
module pwb_tx_chk #(
   parameter int NIB_W      = 4,
   parameter int MAX_NIBS   = 16,
   parameter int CNT_W      = 5,
   parameter int ZERO_CYC   = 9600,
   parameter int ONE_CYC    = 28800,
   parameter int PERIOD_CYC = 48000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] nib_count,
   input logic             bus_pull,
   input logic             busy,
   input logic             done
);

   localparam int RUN_W = $clog2(PERIOD_CYC + 1);
   localparam int SLOT4 = NIB_W * PERIOD_CYC;

   logic [RUN_W-1:0] hi_run;
   int               busy_len;
   logic             good_cnt;

   assign good_cnt = (nib_count != '0) && (nib_count <= CNT_W'(MAX_NIBS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run   <= '0;
         busy_len <= 0;
      end else begin
         hi_run   <= bus_pull ? hi_run + RUN_W'(1) : '0;
         busy_len <= busy ? busy_len + 1 : 0;
      end
   end

   // R2
   assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && good_cnt) |=> (busy && bus_pull));

   // R3 and R4: every low pulse on the bus has one of the two widths.
   assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_pull) |-> (hi_run == RUN_W'(ZERO_CYC) || hi_run == RUN_W'(ONE_CYC)));

   // R7
   assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ((busy_len % SLOT4) == 0 && busy_len >= 2 * SLOT4));

   // R8
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   assert_done_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R10
   assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_pull);

   // R11
   assert_bad_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !good_cnt) |=> !busy);

endmodule

bind pwb_tx pwb_tx_chk #(
   .NIB_W      (NIB_W),
   .MAX_NIBS   (MAX_NIBS),
   .CNT_W      (CNT_W),
   .ZERO_CYC   (ZERO_CYC),
   .ONE_CYC    (ONE_CYC),
   .PERIOD_CYC (PERIOD_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .nib_count (nib_count),
   .bus_pull  (bus_pull),
   .busy      (busy),
   .done      (done)
);

// File: tb/sim_pwb_tx.sv
module sim_pwb_tx;

   localparam int NW = 4;
   localparam int MN = 16;
   localparam int CW = 5;
   localparam int ZC = 2;
   localparam int OC = 5;
   localparam int PC = 8;

   logic              clk   = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CW-1:0]     cnt   = '0;
   logic [MN*NW-1:0]  pl    = '0;
   logic              bus_pull, busy, done;

   int    errors = 0;
   int    checks = 0;
   int    cyc    = 0;
   int    busy_cycles = 0;
   int    hi_run = 0;
   string tag = "R1";

   bit    exp_pull[$];
   bit    rx[$];
   logic  m_busy = 1'b0, m_pull = 1'b0, m_done = 1'b0;

   always #4 clk = ~clk;

   pwb_tx #(
      .NIB_W(NW), .MAX_NIBS(MN), .CLK_HZ(1_000_000),
      .ZERO_US(ZC), .ONE_US(OC), .PERIOD_US(PC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .nib_count(cnt),
      .nibbles(pl), .bus_pull(bus_pull), .busy(busy), .done(done)
   );

   function automatic logic [3:0] ref_ck(input int n, input logic [63:0] p);
      logic [3:0] acc = 4'h0;
      for (int k = 0; k < n; k++) acc = acc ^ p[k*4 +: 4];
      return acc + 4'h1;
   endfunction

   function automatic logic [3:0] nib_of(input int n, input logic [63:0] p, input int k);
      return (k < n) ? p[k*4 +: 4] : ref_ck(n, p);
   endfunction

   // Reference model: expected bus_pull for every cycle of a frame.
   function automatic void load_model(input int n, input logic [63:0] p);
      for (int k = 0; k <= n; k++) begin
         logic [3:0] nb = nib_of(n, p, k);
         for (int b = 3; b >= 0; b--) begin
            int w = nb[b] ? OC : ZC;
            for (int c = 0; c < PC; c++) exp_pull.push_back(c < w);
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_pull.delete();
         m_busy = 1'b0; m_pull = 1'b0; m_done = 1'b0;
      end else begin
         logic was;
         was    = m_busy;
         m_done = 1'b0;
         if (!was && start && cnt != 0 && cnt <= MN) load_model(int'(cnt), pl);
         if (exp_pull.size() > 0) begin
            m_pull = exp_pull.pop_front();
            m_busy = 1'b1;
         end else begin
            m_done = was;
            m_busy = 1'b0;
            m_pull = 1'b0;
         end
      end
   end

   task automatic chk(input string t, input bit ok, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", t, msg);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Every-cycle comparison, pulse decoder and watchdog.
   always @(negedge clk) begin
      cyc++;
      checks++;
      if ({bus_pull, busy, done} !== {m_pull, m_busy, m_done}) begin
         errors++;
         $display("FAIL %s: cycle %0d pull/busy/done=%b%b%b expected %b%b%b",
                  tag, cyc, bus_pull, busy, done, m_pull, m_busy, m_done);
      end
      if (busy === 1'b1) busy_cycles++;
      if (bus_pull === 1'b1) hi_run++;
      else if (hi_run > 0) begin
         rx.push_back(hi_run == OC);
         hi_run = 0;
      end
      if (cyc > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
         summary();
      end
   end

   task automatic go(input string t, input int n, input logic [63:0] p, input bit now);
      if (!now) @(negedge clk);
      tag = t;
      rx.delete();
      busy_cycles = 0;
      cnt = CW'(n); pl = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2", busy === 1'b1 && bus_pull === 1'b1,
          $sformatf("busy=%b pull=%b expected 1 1 after start", busy, bus_pull));
   endtask

   task automatic finish(input int n, input logic [63:0] p);
      int guard = 0;
      while (m_done !== 1'b1 && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      chk("R8", done === 1'b1 && busy === 1'b0,
          $sformatf("done=%b busy=%b expected 1 0", done, busy));
      chk("R10", bus_pull === 1'b0, $sformatf("pull=%b expected 0", bus_pull));
      chk("R7", busy_cycles == (n + 1) * 4 * PC,
          $sformatf("busy cycles=%0d expected %0d", busy_cycles, (n + 1) * 4 * PC));
      begin
         bit ok = (rx.size() == (n + 1) * 4);
         if (ok) begin
            for (int k = 0; k <= n; k++) begin
               logic [3:0] nb = nib_of(n, p, k);
               for (int b = 0; b < 4; b++)
                  if (rx[k*4 + b] != nb[3-b]) ok = 0;
            end
         end
         chk("R5", ok, $sformatf("decoded %0d bits, expected %0d in slot order",
                                 rx.size(), (n + 1) * 4));
         if (rx.size() >= 4) begin
            logic [3:0] got;
            int s = rx.size();
            got = {rx[s-4], rx[s-3], rx[s-2], rx[s-1]};
            chk("R6", got == ref_ck(n, p),
                $sformatf("checksum=%h expected %h", got, ref_ck(n, p)));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", {bus_pull, busy, done} === 3'b000,
          $sformatf("in reset outputs=%b%b%b expected 000", bus_pull, busy, done));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", {bus_pull, busy, done} === 3'b000,
          $sformatf("idle outputs=%b%b%b expected 000", bus_pull, busy, done));

      // Ping-like frame 1,8 -> checksum A.
      go("R6", 2, 64'h81, 0); finish(2, 64'h81);
      // Reply-like frame 9,8 -> checksum 2.
      go("R6", 2, 64'h89, 0); finish(2, 64'h89);
      // Single nibble F -> checksum 0.
      go("R6", 1, 64'hF, 0); finish(1, 64'hF);
      // All-zero payload: every bit is a short pulse (R3).
      go("R3", 3, 64'h000, 0); finish(3, 64'h000);
      // All-ones payload: every bit is a long pulse (R4).
      go("R4", 3, 64'hFFF, 0); finish(3, 64'hFFF);
      // Longest frame (R7).
      go("R7", 16, 64'h0123456789ABCDEF, 0); finish(16, 64'h0123456789ABCDEF);

      // R9: competing request and payload change in mid-frame.
      go("R9", 2, 64'h81, 0);
      repeat (10) @(negedge clk);
      pl = 64'hDEAD; cnt = 5'd4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finish(2, 64'h81);

      // R8: new start placed in the done cycle is accepted.
      go("R8", 2, 64'h3C, 0);
      finish(2, 64'h3C);
      go("R8", 1, 64'h5, 1);
      finish(1, 64'h5);

      // R11: counts of 0 and 17 are ignored.
      tag = "R11";
      @(negedge clk);
      cnt = 5'd0; pl = 64'h12; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11", busy === 1'b0, $sformatf("count 0: busy=%b expected 0", busy));
      cnt = 5'd17; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11", busy === 1'b0, $sformatf("count 17: busy=%b expected 0", busy));
      repeat (12) @(negedge clk);
      chk("R10", {bus_pull, busy} === 2'b00,
          $sformatf("after ignored starts pull/busy=%b%b expected 00", bus_pull, busy));

      repeat (4) @(negedge clk);
      summary();
   end

endmodule